// File: doc/BRIEF.md
# Controlled-Division Clock Synchroniser

The block recovers a local clock that is phase-aligned to the level changes of a received line signal. It runs from one fast clock whose rate is N = 2^DIV_LOG2 times the recovered clock rate (N = 32 by default). A modulo-N counter divides the fast clock, and its most significant bit forms the local clock. The local clock is low for the first half of each count cycle and high for the second half, so its falling edge falls where the count wraps to zero.

A sign-only phase comparator measures each received level change against the most recent falling edge of the local clock. A change in the first half of the local period means the local clock is early, so the counter is held for one fast cycle (a delay). A change in the second half means the local clock is late, so the counter steps by two for one fast cycle (an advance). Each step shifts the local clock by 360°/N. At most one step is applied per local period. The error is always taken from the nearest transition, so it never exceeds 180°.

The last decided direction is held on a sense output until a new transition is compared. A hold input from a coarse synchroniser clears the counter and blocks corrections. The local clock runs at the bit rate for three-level line codes and at twice the bit rate for two-level split-phase codes. All pins are plain control and status pins, and no stream handshake applies.

Top module: `clk_sync_div`

## Requirements
- R1: While reset is asserted and in the first cycle after it, loc_clk, adv_pulse, dly_pulse and lag_sense are all 0.
- R2: With no line transitions and hold low, loc_clk has a period of N fast cycles. It is high for N/2 of them. After a clear, it first rises N/2 fast cycles after the count restarts.
- R3: A change of rx_line (either direction) seen while the count is in 0..N/2-1 raises dly_pulse for exactly one cycle, starting the next cycle. All later loc_clk edges then come one fast cycle later.
- R4: A change of rx_line seen while the count is in N/2..N-1 raises adv_pulse for exactly one cycle, starting the next cycle. All later loc_clk edges then come one fast cycle earlier.
- R5: After one correction, further transitions cause no pulse and no phase change until the count next wraps past N-1 to 0 (the loc_clk falling edge).
- R6: lag_sense is 1 after an advance and 0 after a delay. It keeps its value while no correction occurs, including during hold.
- R7: While div_hold is 1, the count is held at 0, loc_clk stays 0 and no correction pulse occurs, whatever rx_line does.
- R8: adv_pulse and dly_pulse are never 1 in the same cycle.
- R9: The boundary count N/2-1 gives a delay and the count N/2 gives an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, N times the local clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Received coded signal, already synchronous to clk_fast |
| div_hold | input | 1 | Clears the divider and blocks corrections while 1 |
| loc_clk | output | 1 | Recovered local clock |
| adv_pulse | output | 1 | One-cycle pulse when an advance step is applied |
| dly_pulse | output | 1 | One-cycle pulse when a delay step is applied |
| lag_sense | output | 1 | Last decided direction: 1 local late, 0 local early |

## Verification
The hardest case to reach from the ports is a second transition inside a local period that has already been corrected, followed by a transition just after the next wrap. That case shows both that the one-step limit holds and that it is released at the right moment. The bench reaches it by releasing the hold so that the count phase is known exactly. It then counts fast cycles to place changes at chosen phases: 20, then 25 in the same period, then 5 of the next period. The exact boundary phases N/2-1 and N/2 are placed the same way, and each step is checked by timing the next loc_clk edge.

// File: rtl/clk_sync_pkg.sv
package clk_sync_pkg;
  typedef enum logic [1:0] {
    CORR_NONE    = 2'd0,
    CORR_DELAY   = 2'd1,
    CORR_ADVANCE = 2'd2
  } corr_e;
endpackage

// File: rtl/cs_edge_det.sv
module cs_edge_det (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic rx_line,
  output logic rx_prev,
  output logic edge_seen
);
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) rx_prev <= 1'b0;
    else        rx_prev <= rx_line;
  end

  assign edge_seen = rx_line ^ rx_prev;
endmodule

// File: rtl/cs_phase_cmp.sv
module cs_phase_cmp
  import clk_sync_pkg::*;
#(
  parameter int DIV_LOG2 = 5
) (
  input  logic                clk_fast,
  input  logic                rst_n,
  input  logic                edge_seen,
  input  logic                div_hold,
  input  logic                wrap,
  input  logic [DIV_LOG2-1:0] phase,
  output corr_e               corr,
  output logic                adv_pulse,
  output logic                dly_pulse,
  output logic                lag_sense
);
  localparam int N    = 1 << DIV_LOG2;
  localparam int HALF = N / 2;

  logic done;

  always_comb begin
    corr = CORR_NONE;
    if (!div_hold && edge_seen && !done) begin
      if (phase < DIV_LOG2'(HALF)) corr = CORR_DELAY;
      else                         corr = CORR_ADVANCE;
    end
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      adv_pulse <= 1'b0;
      dly_pulse <= 1'b0;
      lag_sense <= 1'b0;
    end else if (div_hold) begin
      done      <= 1'b0;
      adv_pulse <= 1'b0;
      dly_pulse <= 1'b0;
    end else begin
      adv_pulse <= (corr == CORR_ADVANCE);
      dly_pulse <= (corr == CORR_DELAY);
      if (corr != CORR_NONE) begin
        done      <= 1'b1;
        lag_sense <= (corr == CORR_ADVANCE);
      end else if (wrap) begin
        done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cs_divider.sv
module cs_divider
  import clk_sync_pkg::*;
#(
  parameter int DIV_LOG2 = 5
) (
  input  logic                clk_fast,
  input  logic                rst_n,
  input  logic                div_hold,
  input  corr_e               corr,
  output logic [DIV_LOG2-1:0] count,
  output logic                wrap
);
  localparam logic [DIV_LOG2-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (div_hold) begin
      count <= '0;
    end else begin
      unique case (corr)
        CORR_DELAY:   count <= count;
        CORR_ADVANCE: count <= count + DIV_LOG2'(2);
        default:      count <= count + DIV_LOG2'(1);
      endcase
    end
  end

  assign wrap = !div_hold && (corr == CORR_NONE) && (count == CNT_MAX);
endmodule

// File: rtl/clk_sync_div.sv
module clk_sync_div
  import clk_sync_pkg::*;
#(
  parameter int DIV_LOG2 = 5
) (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic rx_line,
  input  logic div_hold,
  output logic loc_clk,
  output logic adv_pulse,
  output logic dly_pulse,
  output logic lag_sense
);
  logic                rx_prev;
  logic                edge_seen;
  logic                wrap;
  logic [DIV_LOG2-1:0] count;
  corr_e               corr;

  cs_edge_det u_edge (
    .clk_fast  (clk_fast),
    .rst_n     (rst_n),
    .rx_line   (rx_line),
    .rx_prev   (rx_prev),
    .edge_seen (edge_seen)
  );

  cs_phase_cmp #(.DIV_LOG2(DIV_LOG2)) u_cmp (
    .clk_fast  (clk_fast),
    .rst_n     (rst_n),
    .edge_seen (edge_seen),
    .div_hold  (div_hold),
    .wrap      (wrap),
    .phase     (count),
    .corr      (corr),
    .adv_pulse (adv_pulse),
    .dly_pulse (dly_pulse),
    .lag_sense (lag_sense)
  );

  cs_divider #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk_fast (clk_fast),
    .rst_n    (rst_n),
    .div_hold (div_hold),
    .corr     (corr),
    .count    (count),
    .wrap     (wrap)
  );

  assign loc_clk = count[DIV_LOG2-1];
endmodule

// File: rtl/cs_checker.sv
module cs_checker (
  input logic clk_fast,
  input logic rst_n,
  input logic rx_line,
  input logic rx_prev,
  input logic div_hold,
  input logic loc_clk,
  input logic adv_pulse,
  input logic dly_pulse,
  input logic lag_sense
);
  a_r8_exclusive: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !(adv_pulse && dly_pulse));

  // R3 and R4: a step needs a line change outside hold in the previous cycle
  a_r4_caused_by_edge: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (adv_pulse || dly_pulse) |-> $past((rx_line != rx_prev) && !div_hold));

  a_r7_hold_quiet: assert property (@(posedge clk_fast) disable iff (!rst_n)
    div_hold |=> (!adv_pulse && !dly_pulse && !loc_clk));

  a_r5_single_step: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (adv_pulse || dly_pulse) |=> !(adv_pulse || dly_pulse));

  a_r6_sense_adv: assert property (@(posedge clk_fast) disable iff (!rst_n)
    adv_pulse |-> lag_sense);

  a_r6_sense_dly: assert property (@(posedge clk_fast) disable iff (!rst_n)
    dly_pulse |-> !lag_sense);

  a_r6_sense_kept: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !(adv_pulse || dly_pulse) |-> $stable(lag_sense));
endmodule

bind clk_sync_div cs_checker u_chk (
  .clk_fast  (clk_fast),
  .rst_n     (rst_n),
  .rx_line   (rx_line),
  .rx_prev   (rx_prev),
  .div_hold  (div_hold),
  .loc_clk   (loc_clk),
  .adv_pulse (adv_pulse),
  .dly_pulse (dly_pulse),
  .lag_sense (lag_sense)
);

// File: tb/clk_sync_div_bench.sv
module clk_sync_div_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 32;
  localparam int HALF = N / 2;

  logic clk_fast = 1'b0;
  logic rst_n    = 1'b0;
  logic rx_line  = 1'b0;
  logic div_hold = 1'b0;
  logic loc_clk, adv_pulse, dly_pulse, lag_sense;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit ended  = 1'b0;

  clk_sync_div u_clk_sync_div (
    .clk_fast  (clk_fast),
    .rst_n     (rst_n),
    .rx_line   (rx_line),
    .div_hold  (div_hold),
    .loc_clk   (loc_clk),
    .adv_pulse (adv_pulse),
    .dly_pulse (dly_pulse),
    .lag_sense (lag_sense)
  );

  always #(CLK_PERIOD/2) clk_fast = ~clk_fast;

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk_fast) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected < 20000", cycles);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_fast);
  endtask

  // Leaves the bench at a negedge with the count at 0.
  task automatic restart();
    @(negedge clk_fast) div_hold = 1'b1;
    step(2);
    div_hold = 1'b0;
  endtask

  // Counts posedges until loc_clk reads lvl at a negedge.
  task automatic cycles_to(input logic lvl, output int n);
    n = 0;
    do begin
      step(1);
      n++;
    end while (loc_clk !== lvl && n < 3*N);
  endtask

  task automatic t_reset();
    step(1);
    check(loc_clk === 1'b0, "R1 loc_clk in reset", loc_clk, 0);
    check(adv_pulse === 1'b0 && dly_pulse === 1'b0, "R1 pulses in reset", adv_pulse|dly_pulse, 0);
    check(lag_sense === 1'b0, "R1 sense in reset", lag_sense, 0);
    rst_n = 1'b1;
    step(1);
    check(loc_clk === 1'b0 && lag_sense === 1'b0, "R1 after reset", loc_clk|lag_sense, 0);
  endtask

  task automatic t_free_run();
    int n;
    restart();
    cycles_to(1'b1, n);
    check(n == HALF, "R2 first rise after clear", n, HALF);
    cycles_to(1'b0, n);
    check(n == HALF, "R2 high width", n, HALF);
    cycles_to(1'b1, n);
    check(n == HALF, "R2 low width", n, HALF);
  endtask

  task automatic t_delay(input int p, input string tag);
    int n;
    restart();
    step(p);
    rx_line = ~rx_line;
    step(1);
    check(dly_pulse === 1'b1 && adv_pulse === 1'b0, {tag, " delay pulse"}, dly_pulse, 1);
    check(lag_sense === 1'b0, {tag, " sense early"}, lag_sense, 0);
    step(1);
    check(dly_pulse === 1'b0, {tag, " pulse width one"}, dly_pulse, 0);
    n = 2;
    while (loc_clk !== 1'b1 && n < 3*N) begin step(1); n++; end
    check(n == HALF + 1 - p, {tag, " rise one late"}, n, HALF + 1 - p);
  endtask

  task automatic t_advance(input int p, input string tag);
    int n;
    restart();
    step(p);
    rx_line = ~rx_line;
    step(1);
    check(adv_pulse === 1'b1 && dly_pulse === 1'b0, {tag, " advance pulse"}, adv_pulse, 1);
    check(lag_sense === 1'b1, {tag, " sense late"}, lag_sense, 1);
    n = 1;
    while (loc_clk !== 1'b0 && n < 3*N) begin step(1); n++; end
    check(n == N - 1 - p, {tag, " fall one early"}, n, N - 1 - p);
  endtask

  task automatic t_one_per_period();
    bit any;
    restart();
    step(20);
    rx_line = ~rx_line;                 // count 20 -> advance, count 22
    step(1);
    check(adv_pulse === 1'b1, "R5 first step taken", adv_pulse, 1);
    step(3);                            // count 25
    rx_line = ~rx_line;
    step(1);
    check(!adv_pulse && !dly_pulse, "R5 second change ignored", adv_pulse|dly_pulse, 0);
    any = 0;
    repeat (5) begin step(1); any |= loc_clk === 1'b0; end
    check(!any, "R5 no extra phase shift", any, 0);
    step(1);
    check(loc_clk === 1'b0, "R5 wrap at expected cycle", loc_clk, 0);
    step(5);                            // count 5 of next period
    rx_line = ~rx_line;
    step(1);
    check(dly_pulse === 1'b1, "R5 step allowed after wrap", dly_pulse, 1);
  endtask

  task automatic t_sense_hold();
    bit any;
    t_advance(20, "R6 setup");
    any = 0;
    repeat (3*N) begin step(1); any |= adv_pulse | dly_pulse; end
    check(!any, "R6 no step without changes", any, 0);
    check(lag_sense === 1'b1, "R6 sense kept idle", lag_sense, 1);
    @(negedge clk_fast) div_hold = 1'b1;
    step(4);
    check(lag_sense === 1'b1, "R6 sense kept in hold", lag_sense, 1);
    div_hold = 1'b0;
  endtask

  task automatic t_hold();
    bit any_pulse, any_high;
    int n;
    @(negedge clk_fast) div_hold = 1'b1;
    step(1);
    any_pulse = 0; any_high = 0;
    for (int i = 0; i < 2*N; i++) begin
      if (i % 3 == 0) rx_line = ~rx_line;
      step(1);
      any_pulse |= adv_pulse | dly_pulse;
      any_high  |= loc_clk;
    end
    check(!any_pulse, "R7 no step in hold", any_pulse, 0);
    check(!any_high, "R7 loc_clk low in hold", any_high, 0);
    div_hold = 1'b0;
    cycles_to(1'b1, n);
    check(n == HALF, "R7 restart from zero", n, HALF);
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_delay(5, "R3");
    t_advance(20, "R4");
    t_delay(HALF - 1, "R9 low edge");
    t_advance(HALF, "R9 high edge");
    t_one_per_period();
    t_sense_hold();
    t_hold();
    // R8 checked on every sampled pulse above; one direct check here
    restart();
    step(HALF);
    rx_line = ~rx_line;
    step(1);
    check(!(adv_pulse && dly_pulse), "R8 exclusive pulses", adv_pulse & dly_pulse, 0);
    finish_run();
  end
endmodule